// File: doc/BRIEF.md
# Error Performance Counter Bank

This block accumulates per-frame error reports for a transport framer's monitoring levels. Eight levels are covered: the section level, the path level and six tandem-connection levels. Each level has one counter for parity (BIP-8) errors and one for backward error indication (BEI) values. Two further counters track positive and negative justification events. Every counter is 16 bits wide and saturates at its maximum instead of wrapping around.

On each frame strobe, every level counter adds an increment. In bit mode the increment is the number of errored bits. In block mode it is a single count for any errored frame. A capture copies all live counts into holding registers and clears the live counts. Software can request a capture, or a periodic sync pulse can trigger one, depending on the selected mode. An interrupt output flags any counter that holds a nonzero live count and is not masked.

Top module: `errcnt_bank`

## Requirements
- R1: After reset, every held count is 0, every live count is 0, and `irqVec` and `irq` are 0.
- R2: Level counters use even indices for parity: level L uses index 2L, where level 0 is section, level 1 is path, and levels 2 to 7 are tandem levels 1 to 6. In bit mode, a frame adds the number of set bits in that level's 8-bit parity difference (`bipDiff[8L+7:8L]`).
- R3: The BEI counter of level L is index 2L+1. In bit mode, a frame adds the 4-bit BEI value (`beiVal[4L+3:4L]`) when it is 0 to 8. A value of 9 to 15 adds 0.
- R4: In block mode (`bitMode[i]`=0), a frame adds 1 when counter i's bit-mode increment would be nonzero, and 0 otherwise. A BEI value above 8 therefore adds 0 in either mode.
- R5: Index 16 counts `posJust` and index 17 counts `negJust`. Each adds 1 on a frame strobe where its input is high.
- R6: A live count never exceeds 65535. Once it reaches 65535 it stays there until a capture.
- R7: With `autoMode`=0, a `latchReq` cycle makes `heldCount` show the live counts from before that edge, and the live counts restart. `syncPulse` has no effect in this mode.
- R8: With `autoMode`=1, `syncPulse` performs the capture and `latchReq` has no effect.
- R9: When a frame strobe and a capture occur in the same cycle, the held value excludes that frame's increment, and the restarted live count equals that increment.
- R10: `irqVec[i]` is 1 exactly when live count i is nonzero and `intMask[i]` is 0. `irq` is the OR of `irqVec`.
- R11: Inputs on cycles with `frameValid`=0 change no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameValid | input | 1 | Frame strobe; error inputs are taken when high |
| bipDiff | input | 64 | Per-level 8-bit parity difference, level L at bits 8L+7:8L |
| beiVal | input | 32 | Per-level 4-bit BEI value, level L at bits 4L+3:4L |
| posJust | input | 1 | Positive justification event this frame |
| negJust | input | 1 | Negative justification event this frame |
| bitMode | input | 16 | Per level counter: 1 = bit counting, 0 = block counting |
| autoMode | input | 1 | 0 = software latch capture, 1 = sync pulse capture |
| latchReq | input | 1 | Software capture strobe |
| syncPulse | input | 1 | Periodic capture strobe |
| intMask | input | 18 | Per counter interrupt mask, 1 = masked |
| heldCount | output | 288 | Held counts, counter i at bits 16i+15:16i |
| irqVec | output | 18 | Per counter unmasked nonzero flag |
| irq | output | 1 | OR of irqVec |

## Verification
The bench drives captures on the same cycle as frame strobes. A design that drops that frame, or folds it into the held value, shows a held or live count off by the increment. BEI values of 9 to 15 are sent in both counting modes. An unclipped design would add up to 15 in bit mode and 1 in block mode. A long run of all-ones parity differences drives every level counter past 65535. A wrapping counter would then show a small held value instead of 65535. Each capture strobe is also sent in the wrong mode, and frame data is sent with the strobe low; a design that reacted to either would change its held counts or interrupt flags.

// File: rtl/errcnt_pkg.sv
package errcnt_pkg;

  typedef struct packed {
    logic frameTick;
    logic capture;
  } ctrlStrobe_t;

  function automatic logic [3:0] onesIn8(input logic [7:0] d);
    logic [3:0] n;
    n = 4'd0;
    for (int k = 0; k < 8; k++) n = n + {3'b000, d[k]};
    return n;
  endfunction

  function automatic logic [3:0] beiClip(input logic [3:0] b);
    return (b > 4'd8) ? 4'd0 : b;
  endfunction

endpackage

// File: rtl/errcnt_ctrl.sv
module errcnt_ctrl
  import errcnt_pkg::*;
(
  input  logic        frameValid,
  input  logic        autoMode,
  input  logic        latchReq,
  input  logic        syncPulse,
  output ctrlStrobe_t strobe
);

  always_comb begin
    strobe.frameTick = frameValid;
    strobe.capture   = autoMode ? syncPulse : latchReq;
  end

endmodule

// File: rtl/errcnt_datapath.sv
module errcnt_datapath
  import errcnt_pkg::*;
#(
  parameter int NUM_LEVELS = 8,
  parameter int CNT_W      = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobe_t                   strobe,
  input  logic [NUM_LEVELS*8-1:0]       bipDiff,
  input  logic [NUM_LEVELS*4-1:0]       beiVal,
  input  logic                          posJust,
  input  logic                          negJust,
  input  logic [2*NUM_LEVELS-1:0]       bitMode,
  input  logic [2*NUM_LEVELS+1:0]       intMask,
  output logic [(2*NUM_LEVELS+2)*CNT_W-1:0] heldCount,
  output logic [(2*NUM_LEVELS+2)*CNT_W-1:0] liveCount,
  output logic [2*NUM_LEVELS+1:0]       irqVec
);

  localparam int NUM_CNT = 2 * NUM_LEVELS + 2;
  localparam int PAD_W   = CNT_W - 3;

  logic [NUM_CNT-1:0][3:0] incVal;

  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
    logic [3:0] bipBits;
    logic [3:0] beiBits;
    assign bipBits = onesIn8(bipDiff[l*8 +: 8]);
    assign beiBits = beiClip(beiVal[l*4 +: 4]);
    assign incVal[2*l]   = bitMode[2*l]   ? bipBits : {3'b000, |bipBits};
    assign incVal[2*l+1] = bitMode[2*l+1] ? beiBits : {3'b000, |beiBits};
  end

  assign incVal[NUM_CNT-2] = {3'b000, posJust};
  assign incVal[NUM_CNT-1] = {3'b000, negJust};

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic [CNT_W-1:0] live;
    logic [CNT_W-1:0] held;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] incExt;
    logic [CNT_W-1:0] satSum;

    assign incExt = {{PAD_W{1'b0}}, incVal[i]};
    assign sum    = {1'b0, live} + {1'b0, incExt};
    assign satSum = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        live <= '0;
        held <= '0;
      end else if (strobe.capture) begin
        held <= live;
        live <= strobe.frameTick ? incExt : '0;
      end else if (strobe.frameTick) begin
        live <= satSum;
      end
    end

    assign heldCount[i*CNT_W +: CNT_W] = held;
    assign liveCount[i*CNT_W +: CNT_W] = live;
    assign irqVec[i] = (live != '0) && !intMask[i];
  end

endmodule

// File: rtl/errcnt_bank.sv
module errcnt_bank
  import errcnt_pkg::*;
#(
  parameter int NUM_LEVELS = 8,
  parameter int CNT_W      = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              frameValid,
  input  logic [NUM_LEVELS*8-1:0]           bipDiff,
  input  logic [NUM_LEVELS*4-1:0]           beiVal,
  input  logic                              posJust,
  input  logic                              negJust,
  input  logic [2*NUM_LEVELS-1:0]           bitMode,
  input  logic                              autoMode,
  input  logic                              latchReq,
  input  logic                              syncPulse,
  input  logic [2*NUM_LEVELS+1:0]           intMask,
  output logic [(2*NUM_LEVELS+2)*CNT_W-1:0] heldCount,
  output logic [2*NUM_LEVELS+1:0]           irqVec,
  output logic                              irq
);

  localparam int NUM_CNT = 2 * NUM_LEVELS + 2;

  ctrlStrobe_t              strobe;
  logic [NUM_CNT*CNT_W-1:0] liveCount;

  errcnt_ctrl i_ctrl (
    .frameValid (frameValid),
    .autoMode   (autoMode),
    .latchReq   (latchReq),
    .syncPulse  (syncPulse),
    .strobe     (strobe)
  );

  errcnt_datapath #(
    .NUM_LEVELS (NUM_LEVELS),
    .CNT_W      (CNT_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .bipDiff   (bipDiff),
    .beiVal    (beiVal),
    .posJust   (posJust),
    .negJust   (negJust),
    .bitMode   (bitMode),
    .intMask   (intMask),
    .heldCount (heldCount),
    .liveCount (liveCount),
    .irqVec    (irqVec)
  );

  assign irq = |irqVec;

endmodule

// File: rtl/errcnt_checker.sv
module errcnt_checker #(
  parameter int NUM_LEVELS = 8,
  parameter int CNT_W      = 16
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              frameValid,
  input logic                              autoMode,
  input logic                              latchReq,
  input logic                              syncPulse,
  input logic [2*NUM_LEVELS+1:0]           intMask,
  input logic [(2*NUM_LEVELS+2)*CNT_W-1:0] heldCount,
  input logic [(2*NUM_LEVELS+2)*CNT_W-1:0] liveCount,
  input logic [2*NUM_LEVELS+1:0]           irqVec,
  input logic                              irq
);

  localparam int NUM_CNT = 2 * NUM_LEVELS + 2;
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic capSeen;
  assign capSeen = autoMode ? syncPulse : latchReq;

  // R7 R8: held values move only on a capture in the selected mode
  assert_held_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    !capSeen |=> $stable(heldCount));

  // R9: a capture shows the live counts from before its edge
  assert_capture_value_R9: assert property (@(posedge clk) disable iff (!rstN)
    capSeen |=> heldCount == $past(liveCount));

  // R7: a capture with no frame leaves all live counts at zero
  assert_capture_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (capSeen && !frameValid) |=> irqVec == '0);

  // R10: full masking silences the interrupt
  assert_mask_all_R10: assert property (@(posedge clk) disable iff (!rstN)
    (&intMask) |-> !irq);

  // R11: no frame and no capture leaves live counts unchanged
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!frameValid && !capSeen) |=> $stable(liveCount));

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_sat
    // R6: a saturated counter stays saturated until captured
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
      (liveCount[i*CNT_W +: CNT_W] == TOP && !capSeen) |=>
        liveCount[i*CNT_W +: CNT_W] == TOP);
  end

endmodule

bind errcnt_bank errcnt_checker #(
  .NUM_LEVELS (NUM_LEVELS),
  .CNT_W      (CNT_W)
) i_checker (
  .clk        (clk),
  .rstN       (rstN),
  .frameValid (frameValid),
  .autoMode   (autoMode),
  .latchReq   (latchReq),
  .syncPulse  (syncPulse),
  .intMask    (intMask),
  .heldCount  (heldCount),
  .liveCount  (liveCount),
  .irqVec     (irqVec),
  .irq        (irq)
);

// File: tb/test_errcnt_bank.sv
`timescale 1ns/1ps
module test_errcnt_bank;

  localparam int LV   = 8;
  localparam int W    = 16;
  localparam int NC   = 2 * LV + 2;
  localparam int MAXC = (1 << W) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rstN;
  logic              frameValid;
  logic [LV*8-1:0]   bipDiff;
  logic [LV*4-1:0]   beiVal;
  logic              posJust, negJust;
  logic [2*LV-1:0]   bitMode;
  logic              autoMode, latchReq, syncPulse;
  logic [NC-1:0]     intMask;
  logic [NC*W-1:0]   heldCount;
  logic [NC-1:0]     irqVec;
  logic              irq;

  errcnt_bank i_errcnt_bank (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .bipDiff(bipDiff),
    .beiVal(beiVal), .posJust(posJust), .negJust(negJust), .bitMode(bitMode),
    .autoMode(autoMode), .latchReq(latchReq), .syncPulse(syncPulse),
    .intMask(intMask), .heldCount(heldCount), .irqVec(irqVec), .irq(irq)
  );

  int    live [NC];
  int    held [NC];
  int    nChecks = 0;
  int    nErr = 0;
  string curReq = "R1";
  bit    done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int refInc(input int i);
    int v;
    if (!frameValid) return 0;
    if (i == 2*LV)   return int'(posJust);
    if (i == 2*LV+1) return int'(negJust);
    if (i % 2 == 0) v = $countones(bipDiff[(i/2)*8 +: 8]);
    else begin
      v = int'(beiVal[(i/2)*4 +: 4]);
      if (v > 8) v = 0;
    end
    if (!bitMode[i]) v = (v != 0) ? 1 : 0;
    return v;
  endfunction

  // one clock: predict, advance, compare away from the edge
  task automatic tick();
    bit cap;
    int inc;
    cap = autoMode ? syncPulse : latchReq;
    for (int i = 0; i < NC; i++) begin
      inc = refInc(i);
      if (cap) begin
        held[i] = live[i];
        live[i] = inc;
      end else begin
        live[i] = live[i] + inc;
        if (live[i] > MAXC) live[i] = MAXC;
      end
    end
    @(posedge clk);
    @(negedge clk);
    begin
      bit ok = 1'b1;
      int badI = 0;
      for (int i = 0; i < NC; i++)
        if (ok && int'(heldCount[i*W +: W]) != held[i]) begin
          ok = 1'b0; badI = i;
        end
      check(ok, curReq, $sformatf("heldCount[%0d]", badI),
            heldCount[badI*W +: W], held[badI]);
    end
    begin
      logic [NC-1:0] expVec;
      for (int i = 0; i < NC; i++) expVec[i] = (live[i] != 0) && !intMask[i];
      check(irqVec == expVec, "R10", "irqVec", irqVec, expVec);
      check(irq == |expVec, "R10", "irq", irq, |expVec);
    end
  endtask

  task automatic idleInputs();
    frameValid = 0; bipDiff = '0; beiVal = '0; posJust = 0; negJust = 0;
    latchReq = 0; syncPulse = 0;
  endtask

  task automatic randFrame(input int pFrame, input int pLatch, input int pSync);
    frameValid = ($urandom_range(99) < pFrame);
    for (int l = 0; l < LV; l++) begin
      bipDiff[l*8 +: 8] = ($urandom_range(3) == 0) ? 8'h00 : 8'($urandom);
      beiVal[l*4 +: 4]  = 4'($urandom);
    end
    posJust   = $urandom_range(1);
    negJust   = $urandom_range(1);
    latchReq  = ($urandom_range(99) < pLatch);
    syncPulse = ($urandom_range(99) < pSync);
  endtask

  initial begin
    #(150000 * 4);
    if (!done) begin
      nErr++; nChecks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NC; i++) begin live[i] = 0; held[i] = 0; end
    rstN = 0; idleInputs(); bitMode = '1; autoMode = 0; intMask = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int i = 0; i < NC; i++)
      check(heldCount[i*W +: W] == '0, "R1", "heldCount after reset", heldCount[i*W +: W], 0);
    check(irq == 1'b0, "R1", "irq after reset", irq, 0);
    rstN = 1;

    // R2 R3 R5 R7 R11: bit mode, software capture, sync ignored
    curReq = "R2 R3 R5 R7 R11";
    for (int n = 0; n < 400; n++) begin randFrame(70, 10, 20); tick(); end
    idleInputs(); latchReq = 1; tick(); idleInputs();

    // R3: out-of-range BEI counted as zero in bit mode
    curReq = "R3";
    for (int l = 0; l < LV; l++) beiVal[l*4 +: 4] = 4'(9 + l % 7);
    frameValid = 1; tick(); idleInputs(); latchReq = 1; tick(); idleInputs();
    for (int l = 0; l < LV; l++)
      check(heldCount[(2*l+1)*W +: W] == '0, "R3", "BEI above 8", heldCount[(2*l+1)*W +: W], 0);

    // R4: block counting, including BEI above 8
    curReq = "R4";
    bitMode = '0;
    for (int n = 0; n < 400; n++) begin randFrame(70, 10, 20); tick(); end
    bipDiff = {LV{8'hFF}}; beiVal = {LV{4'd8}}; frameValid = 1; latchReq = 1; tick();
    idleInputs(); latchReq = 1; tick(); idleInputs();
    check(heldCount[0 +: W] == 16'd1, "R4", "block count of 8 bit errors", heldCount[0 +: W], 1);

    // R2 R4: mixed per-counter modes
    curReq = "R2 R4";
    for (int n = 0; n < 400; n++) begin
      if (n % 50 == 0) bitMode = 16'($urandom);
      randFrame(70, 10, 20); tick();
    end

    // R8: sync capture, software strobe ignored
    curReq = "R8";
    autoMode = 1;
    for (int n = 0; n < 600; n++) begin
      randFrame(70, 20, 0);
      syncPulse = (n % 37 == 36);
      tick();
    end
    idleInputs();

    // R9: increment coincident with capture
    curReq = "R9";
    bitMode = '1;
    syncPulse = 1; tick(); idleInputs();
    bipDiff[7:0] = 8'h03; frameValid = 1; tick(); tick();
    bipDiff[7:0] = 8'h01; syncPulse = 1; tick(); idleInputs();
    check(heldCount[0 +: W] == 16'd4, "R9", "held excludes coincident frame", heldCount[0 +: W], 4);
    syncPulse = 1; tick(); idleInputs();
    check(heldCount[0 +: W] == 16'd1, "R9", "coincident frame kept live", heldCount[0 +: W], 1);
    autoMode = 0;

    // R10: random masks
    curReq = "R10";
    for (int n = 0; n < 300; n++) begin
      if (n % 20 == 0) intMask = 18'($urandom);
      randFrame(60, 8, 8); tick();
    end
    intMask = '1; randFrame(100, 0, 0); tick();
    check(irq == 1'b0, "R10", "irq with all masked", irq, 0);
    intMask = '0;

    // R6: saturation
    curReq = "R6";
    idleInputs(); latchReq = 1; tick(); idleInputs();
    bipDiff = {LV{8'hFF}}; beiVal = {LV{4'd8}}; posJust = 1; negJust = 0; frameValid = 1;
    for (int n = 0; n < 8200; n++) tick();
    idleInputs(); latchReq = 1; tick(); idleInputs();
    for (int i = 0; i < 2*LV; i++)
      check(int'(heldCount[i*W +: W]) == MAXC, "R6", $sformatf("saturated counter %0d", i),
            heldCount[i*W +: W], MAXC);
    check(int'(heldCount[2*LV*W +: W]) == 8200, "R5", "justification count", heldCount[2*LV*W +: W], 8200);
    check(heldCount[(2*LV+1)*W +: W] == '0, "R5", "negative justification idle", heldCount[(2*LV+1)*W +: W], 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule